// File: doc/BRIEF.md
# Stacked Interrupt Status Controller

This block gathers single-cycle interrupt event pulses from a bus-protocol engine (two status groups, A and B) and a DMA engine (one status group) into three first-level status registers. Each status bit belongs to a fixed class, fatal or nonfatal, given by a per-group parameter vector. Each group also has a per-bit enable mask, where 1 means enabled. The block keeps two pending flags, one for the protocol groups and one for the DMA group. It drives an active-low interrupt pin and a one-cycle halt request for the instruction sequencer.

A mask only keeps an event off the pin. A masked fatal event still raises its pending flag and the halt request, but a masked nonfatal event only records its status bit. While anything is pending, new events are not written into the first level. They go into a second-level shadow register behind each status register, and further events merge into it by OR.

Software reads a first-level register through a simple read port. The read returns the register and clears it. When all three first-level registers are empty, the second level moves into the first level on the next cycle, and the pending flags and the pin are evaluated again against the masks in force at that time.

Top module: `isc_ctrl`

## Requirements
- R1: A masked nonfatal event sets its first-level status bit but leaves its pending flag clear, keeps `irq_n` high and raises no halt.
- R2: A fatal event, masked or not, sets its status bit and its group's pending flag. It also drives `halt_req` high for exactly the cycle after the event. If it is masked, `irq_n` stays high.
- R3: An enabled event of either class sets its status bit and pending flag and pulls `irq_n` low one cycle later. A nonfatal event never raises `halt_req`.
- R4: Clearing mask bits while `irq_n` is low does not release the pin as long as a pending flag is still set.
- R5: While either pending flag is set and no read is in progress, a new event goes to the second level of its group, and all first-level registers keep their contents.
- R6: Events that arrive while the second level already holds bits are OR-merged into it. No second-level bit is lost until promotion.
- R7: `rd_data` shows the first-level register picked by `rd_sel` in the same cycle. Encodings: 0 is group A, 1 is group B, 2 is DMA, and 3 reads as zero. A cycle with `rd_en` high clears that register. A pending flag clears once every first-level register of its class is empty.
- R8: When all first-level registers are empty and the second level holds bits, the second level moves to the first level on the next clock edge. The pending flags are then recomputed with the current masks.
- R9: `irq_n` is registered and high after reset. It returns high only when both pending flags are clear and no enabled bit is left in the first level.
- R10: An event that arrives in the same cycle as a clearing read goes to the first level if the second level is empty, and to the second level otherwise.
- R11: After reset, both pending flags, `halt_req` and every status register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_bus_a | input | STAT_W | Event pulses, protocol group A |
| ev_bus_b | input | STAT_W | Event pulses, protocol group B |
| ev_dma | input | STAT_W | Event pulses, DMA group |
| en_bus_a | input | STAT_W | Enable mask, group A (1 = enabled) |
| en_bus_b | input | STAT_W | Enable mask, group B |
| en_dma | input | STAT_W | Enable mask, DMA group |
| rd_en | input | 1 | Clearing read strobe |
| rd_sel | input | 2 | Register select: 0 A, 1 B, 2 DMA, 3 none |
| rd_data | output | STAT_W | Selected first-level contents |
| pend_bus | output | 1 | Protocol-engine pending flag |
| pend_dma | output | 1 | DMA pending flag |
| irq_n | output | 1 | Active-low interrupt pin |
| halt_req | output | 1 | One-cycle halt request on a fatal event |

## Verification
The assertions assume three things about the inputs. Event vectors are pulses that are valid at the clock edge. `rd_sel` is stable whenever `rd_en` is high. Reset is held for at least one edge before any checked behaviour starts. The bench changes every input one nanosecond after a rising edge and drops the event and read lines back to zero after each edge, so each event is seen exactly once. It then steps through masked and enabled events of both classes, stacking while a flag is pending, events that coincide with reads, and promotion after the last read.

// File: rtl/isc_pkg.sv
`timescale 1ns/1ps
package isc_pkg;
    localparam int unsigned GRP_N     = 3;
    localparam int unsigned GRP_BUS_A = 0;
    localparam int unsigned GRP_BUS_B = 1;
    localparam int unsigned GRP_DMA   = 2;

    typedef enum logic [1:0] {
        SEL_BUS_A = 2'd0,
        SEL_BUS_B = 2'd1,
        SEL_DMA   = 2'd2,
        SEL_NONE  = 2'd3
    } isc_sel_e;

    typedef struct packed {
        logic pend_bus;
        logic pend_dma;
        logic irq;
        logic halt;
    } isc_sum_t;

    function automatic isc_sel_e sel_decode(input logic [1:0] raw);
        case (raw)
            2'd0:    return SEL_BUS_A;
            2'd1:    return SEL_BUS_B;
            2'd2:    return SEL_DMA;
            default: return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/isc_level_stack.sv
`timescale 1ns/1ps
module isc_level_stack #(
    parameter int unsigned STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] evt,
    input  logic              route_l2,
    input  logic              promote,
    input  logic              clr,
    output logic [STAT_W-1:0] l1_q,
    output logic [STAT_W-1:0] l2_q,
    output logic [STAT_W-1:0] l1_nxt,
    output logic [STAT_W-1:0] l1_in
);
    logic [STAT_W-1:0] l2_nxt;

    always_comb begin
        if (promote) begin
            l1_in  = l2_q | evt;
            l1_nxt = l1_in;
            l2_nxt = '0;
        end else begin
            l1_in  = route_l2 ? '0 : evt;
            l1_nxt = (clr ? '0 : l1_q) | l1_in;
            l2_nxt = l2_q | (route_l2 ? evt : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l1_q <= '0;
            l2_q <= '0;
        end else begin
            l1_q <= l1_nxt;
            l2_q <= l2_nxt;
        end
    end

    // R6
    l2_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !promote |=> (($past(l2_q) & ~l2_q) == '0));
    // R8
    l2_drain_chk: assert property (@(posedge clk) disable iff (rst)
        promote |=> (l2_q == '0));
    // R7
    clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !promote && evt == '0) |=> (l1_q == '0));
endmodule

// File: rtl/isc_summary.sv
`timescale 1ns/1ps
module isc_summary
    import isc_pkg::*;
#(
    parameter int unsigned                          STAT_W  = 8,
    parameter logic [GRP_N-1:0][STAT_W-1:0]         FATAL_V = '0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [GRP_N-1:0][STAT_W-1:0]  evt,
    input  logic [GRP_N-1:0][STAT_W-1:0]  en,
    input  logic [GRP_N-1:0][STAT_W-1:0]  l1_in,
    input  logic [GRP_N-1:0][STAT_W-1:0]  l1_nxt,
    output isc_sum_t                      sum_q
);
    logic [GRP_N-1:0] hit_qual;
    logic [GRP_N-1:0] hit_en;
    logic [GRP_N-1:0] rem_en;
    logic [GRP_N-1:0] fat;
    logic             bus_live;
    logic             dma_live;
    logic             fat_any;
    isc_sum_t         sum_nxt;

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        always_comb begin
            hit_qual[g] = |(l1_in[g] & (FATAL_V[g] | en[g]));
            hit_en[g]   = |(l1_in[g] & en[g]);
            rem_en[g]   = |(l1_nxt[g] & en[g]);
            fat[g]      = |(evt[g] & FATAL_V[g]);
        end
    end

    always_comb begin
        bus_live         = |(l1_nxt[GRP_BUS_A] | l1_nxt[GRP_BUS_B]);
        dma_live         = |l1_nxt[GRP_DMA];
        fat_any          = |fat;
        sum_nxt.pend_bus = bus_live &
                           (sum_q.pend_bus | hit_qual[GRP_BUS_A] | hit_qual[GRP_BUS_B]);
        sum_nxt.pend_dma = dma_live & (sum_q.pend_dma | hit_qual[GRP_DMA]);
        sum_nxt.irq      = (|hit_en) |
                           (sum_q.irq & (sum_nxt.pend_bus | sum_nxt.pend_dma | (|rem_en)));
        sum_nxt.halt     = fat_any;
    end

    always_ff @(posedge clk) begin
        if (rst) sum_q <= '0;
        else     sum_q <= sum_nxt;
    end

    // R9
    irq_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sum_q.irq) |-> (!sum_q.pend_bus && !sum_q.pend_dma));
    // R2
    halt_fatal_chk: assert property (@(posedge clk) disable iff (rst)
        fat_any |=> sum_q.halt);
    // R3
    halt_source_chk: assert property (@(posedge clk) disable iff (rst)
        sum_q.halt |-> $past(fat_any));
endmodule

// File: rtl/isc_ctrl.sv
`timescale 1ns/1ps
module isc_ctrl
    import isc_pkg::*;
#(
    parameter int unsigned       STAT_W  = 8,
    parameter logic [STAT_W-1:0] FATAL_A = 8'h0F,
    parameter logic [STAT_W-1:0] FATAL_B = 8'h01,
    parameter logic [STAT_W-1:0] FATAL_D = 8'h7F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] ev_bus_a,
    input  logic [STAT_W-1:0] ev_bus_b,
    input  logic [STAT_W-1:0] ev_dma,
    input  logic [STAT_W-1:0] en_bus_a,
    input  logic [STAT_W-1:0] en_bus_b,
    input  logic [STAT_W-1:0] en_dma,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic [STAT_W-1:0] rd_data,
    output logic              pend_bus,
    output logic              pend_dma,
    output logic              irq_n,
    output logic              halt_req
);
    localparam logic [GRP_N-1:0][STAT_W-1:0] FATAL_V = {FATAL_D, FATAL_B, FATAL_A};

    logic [GRP_N-1:0][STAT_W-1:0] evt_v, en_v, l1_q, l2_q, l1_nxt, l1_in;
    logic [GRP_N-1:0]             clr_v;
    logic                         l1_empty, l2_any, promote, route_l2, pend_any;
    isc_sel_e                     sel;
    isc_sum_t                     sum_q;

    assign evt_v = {ev_dma, ev_bus_b, ev_bus_a};
    assign en_v  = {en_dma, en_bus_b, en_bus_a};
    assign sel   = sel_decode(rd_sel);

    always_comb begin
        l1_empty = (l1_q == '0);
        l2_any   = (l2_q != '0);
        pend_any = sum_q.pend_bus | sum_q.pend_dma;
        promote  = l1_empty & l2_any;
        route_l2 = !promote && (l2_any || (pend_any && !rd_en));
    end

    for (genvar g = 0; g < GRP_N; g++) begin : g_stack
        assign clr_v[g] = rd_en && (rd_sel == 2'(g));
        isc_level_stack #(.STAT_W(STAT_W)) u_stack (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt_v[g]),
            .route_l2 (route_l2),
            .promote  (promote),
            .clr      (clr_v[g]),
            .l1_q     (l1_q[g]),
            .l2_q     (l2_q[g]),
            .l1_nxt   (l1_nxt[g]),
            .l1_in    (l1_in[g])
        );
    end

    isc_summary #(.STAT_W(STAT_W), .FATAL_V(FATAL_V)) u_sum (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_v),
        .en     (en_v),
        .l1_in  (l1_in),
        .l1_nxt (l1_nxt),
        .sum_q  (sum_q)
    );

    always_comb begin
        case (sel)
            SEL_BUS_A: rd_data = l1_q[GRP_BUS_A];
            SEL_BUS_B: rd_data = l1_q[GRP_BUS_B];
            SEL_DMA:   rd_data = l1_q[GRP_DMA];
            default:   rd_data = '0;
        endcase
    end

    assign pend_bus = sum_q.pend_bus;
    assign pend_dma = sum_q.pend_dma;
    assign irq_n    = ~sum_q.irq;
    assign halt_req = sum_q.halt;

    // R5
    stack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_any && !rd_en && !promote) |=> (l1_q == $past(l1_q)));
    // R8
    promote_fill_chk: assert property (@(posedge clk) disable iff (rst)
        promote |=> ((l1_q & $past(l2_q)) == $past(l2_q)));
endmodule

// File: tb/isc_ctrl_test.sv
`timescale 1ns/1ps
module isc_ctrl_test;
    localparam int W = 8;

    typedef struct {
        logic  irq_n;
        logic  pb;
        logic  pd;
        logic  halt;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] ev_a = '0, ev_b = '0, ev_d = '0;
    logic [W-1:0] en_a = '0, en_b = '0, en_d = '0;
    logic         rd_en = 1'b0;
    logic [1:0]   rd_sel = 2'd0;
    logic [W-1:0] rd_data;
    logic         pend_bus, pend_dma, irq_n, halt_req;

    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    isc_ctrl uut (
        .clk(clk), .rst(rst),
        .ev_bus_a(ev_a), .ev_bus_b(ev_b), .ev_dma(ev_d),
        .en_bus_a(en_a), .en_bus_b(en_b), .en_dma(en_d),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .pend_bus(pend_bus), .pend_dma(pend_dma),
        .irq_n(irq_n), .halt_req(halt_req)
    );

    // monitor: pops one expectation per falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if ({irq_n, pend_bus, pend_dma, halt_req} !== {e.irq_n, e.pb, e.pd, e.halt}) begin
                errors++;
                $display("FAIL %s: got irq_n=%b pend_bus=%b pend_dma=%b halt=%b, expected %b %b %b %b",
                         e.tag, irq_n, pend_bus, pend_dma, halt_req,
                         e.irq_n, e.pb, e.pd, e.halt);
            end
        end
    end

    task automatic ev(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] d);
        ev_a = a; ev_b = b; ev_d = d;
    endtask

    task automatic rd(input logic [1:0] s);
        rd_en = 1'b1; rd_sel = s;
    endtask

    // driver: one clock edge, then queue what the outputs must show after it
    task automatic step(input logic i, input logic pb, input logic pd,
                        input logic h, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        e.irq_n = i; e.pb = pb; e.pd = pd; e.halt = h; e.tag = tag;
        sb.push_back(e);
        ev('0, '0, '0);
        rd_en = 1'b0;
    endtask

    task automatic chk_rd(input logic [1:0] s, input logic [W-1:0] exp, input string tag);
        rd_sel = s;
        #0.1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s: rd_data got %h expected %h", tag, rd_data, exp);
        end
    endtask

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        step(1, 0, 0, 0, "R11 reset idle");
        chk_rd(2'd0, 8'h00, "R11 reset A");
        chk_rd(2'd2, 8'h00, "R11 reset DMA");

        // R1 masked nonfatal on group A bit4
        ev(8'h10, 0, 0);
        step(1, 0, 0, 0, "R1 masked nonfatal");
        chk_rd(2'd0, 8'h10, "R1 status set");
        rd(2'd0);
        step(1, 0, 0, 0, "R7 read clears");
        chk_rd(2'd0, 8'h00, "R7 cleared");

        // R2 masked fatal on group A bit0
        ev(8'h01, 0, 0);
        step(1, 1, 0, 1, "R2 masked fatal");
        step(1, 1, 0, 0, "R2 halt one cycle");
        chk_rd(2'd0, 8'h01, "R2 status set");
        rd(2'd0);
        step(1, 0, 0, 0, "R7 pending clears");

        // R3/R4 enabled nonfatal DMA bit7, then mask removed
        en_d = 8'h80;
        ev(0, 0, 8'h80);
        step(0, 0, 1, 0, "R3 enabled nonfatal");
        en_d = 8'h00;
        step(0, 0, 1, 0, "R4 mask change keeps pin");
        chk_rd(2'd2, 8'h80, "R7 DMA read data");
        rd(2'd2);
        step(1, 0, 0, 0, "R9 pin released");

        // R5/R6 stacking, R8 promotion
        en_a = 8'hFF;
        ev(8'h01, 0, 0);
        step(0, 1, 0, 1, "R3 enabled fatal");
        ev(0, 8'h02, 0);
        step(0, 1, 0, 0, "R5 event to second level");
        ev(0, 8'h04, 8'h01);
        step(0, 1, 0, 1, "R6 merge into second level");
        chk_rd(2'd1, 8'h00, "R5 first level B untouched");
        chk_rd(2'd2, 8'h00, "R5 first level DMA untouched");
        rd(2'd1);
        step(0, 1, 0, 0, "R5 read of empty B");
        chk_rd(2'd0, 8'h01, "R5 first level A kept");
        rd(2'd0);
        step(1, 0, 0, 0, "R9 release before promotion");
        step(1, 0, 1, 0, "R8 promotion recomputes flags");
        chk_rd(2'd1, 8'h06, "R6 merged bits promoted");
        chk_rd(2'd2, 8'h01, "R8 DMA promoted");
        rd(2'd1);
        step(1, 0, 1, 0, "R7 read B");
        rd(2'd2);
        step(1, 0, 0, 0, "R7 read DMA");

        // R10 event during read, second level empty
        ev(8'h20, 0, 0);
        step(0, 1, 0, 0, "R3 enabled nonfatal A");
        chk_rd(2'd3, 8'h00, "R7 select 3 reads zero");
        chk_rd(2'd0, 8'h20, "R10 before read");
        rd(2'd0);
        ev(8'h40, 0, 0);
        step(0, 1, 0, 0, "R10 event to first level");
        chk_rd(2'd0, 8'h40, "R10 first level got event");
        rd(2'd0);
        step(1, 0, 0, 0, "R9 release");

        // R10 event during read, second level non-empty
        ev(8'h20, 0, 0);
        step(0, 1, 0, 0, "R3 pending again");
        ev(0, 8'h08, 0);
        step(0, 1, 0, 0, "R5 stack B bit3");
        rd(2'd0);
        ev(0, 8'h10, 0);
        step(1, 0, 0, 0, "R10 event to second level");
        step(1, 0, 0, 0, "R8 promotion masked nonfatal");
        chk_rd(2'd1, 8'h18, "R10 merged into second level");
        rd(2'd1);
        step(1, 0, 0, 0, "R7 final read");
        chk_rd(2'd1, 8'h00, "R7 final empty");

        @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule